// File: doc/BRIEF.md
# Security Code Verification Unit

This unit guards write and erase access to a storage device behind a three-byte secret. It keeps a small security store of four byte slots. Slot 0 carries a three-bit attempt counter in its low bits. Slots 1 to 3 hold the secret reference code. The host drives one decoded command per cycle: update a slot, compare a guess against a slot, or read a slot. The unit answers each update or compare with a done pulse and a pass/fail flag. It answers each read with a valid pulse and a data byte. The `unlocked` flag tells the rest of the device whether changes are allowed.

After power-on the unit is locked. To open it, the host must first spend one attempt by clearing exactly one counter bit that is still set. It must then compare slot 1, slot 2 and slot 3, in that order. Each compare must match. Any break in that order, or any mismatch, sends the sequencer back to its start point, and the spent bit stays spent. Once all counter bits are spent and no attempt is in progress, the unit refuses everything except reads, for good. Once open, it stays open until the next reset. While open, every slot, including the counter, can be written freely. The host restores the counter by writing 0xFF to slot 0.

Sequencer states, from the `sc_state_t` type:
- `ST_IDLE`: locked, with no attempt under way.
- `ST_VERIFY`: locked, with an attempt under way. A step index records how many reference bytes have matched so far.
- `ST_OPEN`: unlocked.
- `ST_BLOCKED`: locked, with the counter exhausted.

Transitions:
- **arm**: from `ST_IDLE` or `ST_VERIFY` to `ST_VERIFY` with step 0. Taken on a slot-0 update that clears exactly one set counter bit.
- **advance**: within `ST_VERIFY`. Taken on a matching compare of slot step+1 while step is below 2. The step index goes up by one.
- **open**: from `ST_VERIFY` with step 2 to `ST_OPEN`. Taken on a matching compare of slot 3.
- **abandon**: from `ST_IDLE` or `ST_VERIFY` to `ST_IDLE`. Taken on any other update or compare while locked, when counter bits remain.
- **exhaust**: the same cases as abandon, but the counter is zero afterwards, so the target is `ST_BLOCKED`.

Top module: `seccode_unit`

## Requirements
- R1: After reset the unit is locked. `cmd_done`, `cmd_ok`, `rd_valid` and `rd_data` are 0, the counter holds its initial value (3'b111 by default), and the reference bytes hold their initial values (slot 1 = 0x5A, slot 2 = 0xC3, slot 3 = 0x17 by default).
- R2: A read of slot 0 returns the counter in bits 2:0 and zeros in bits 7:3. Slot addresses are 0 for the counter and 1, 2, 3 for the reference bytes.
- R3: While locked, a slot-0 update stores the old counter ANDed with wdata[2:0], so a counter bit can only go from 1 to 0.
- R4: While locked, an update to slot 1, 2 or 3 is refused. It gives `cmd_ok`=0 and leaves the stored byte unchanged.
- R5: A slot-0 update that clears exactly one set counter bit gives `cmd_ok`=1 and arms the sequencer. Matching compares of slots 1, 2 and 3 in that order then each give `cmd_ok`=1, and `unlocked` rises with the response to the third compare.
- R6: A compare that arrives unarmed, or that names a slot other than the next one expected, gives `cmd_ok`=0. It returns the sequencer to its start point, so a later correct compare also fails until the unit is armed again.
- R7: A compare whose data differs from the expected reference byte gives `cmd_ok`=0. The unit stays locked, the spent counter bit stays cleared, and the attempt ends.
- R8: When the counter is zero and no attempt is under way, every update and compare gives `cmd_ok`=0 and the unit stays locked.
- R9: While locked, reads of slots 1 to 3 return 0x00.
- R10: Once unlocked, the unit stays unlocked until reset. Updates to any slot write the full data: wdata[2:0] for the counter, all eight bits for a reference byte. Each such update gives `cmd_ok`=1, and reference bytes read back in clear.
- R11: `cmd_done` pulses high for exactly one cycle, one cycle after an update or compare strobe. `rd_valid` pulses high, with `rd_data`, one cycle after a read strobe. If several strobes are high together, update wins over compare, and compare wins over read.
- R12: While locked, a slot-0 update that clears no set bit, or more than one set bit, still applies the AND rule. It gives `cmd_ok`=0 and does not arm the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| upd_stb | input | 1 | Update-slot command strobe |
| cmp_stb | input | 1 | Compare-slot command strobe |
| rd_stb | input | 1 | Read-slot command strobe |
| addr | input | 2 | Slot address (0 counter, 1 to 3 reference) |
| wdata | input | 8 | Update data or compare guess |
| unlocked | output | 1 | High once verification has succeeded |
| cmd_done | output | 1 | One-cycle response to an update or compare |
| cmd_ok | output | 1 | Pass/fail of that update or compare |
| rd_valid | output | 1 | One-cycle read response |
| rd_data | output | 8 | Read data |

## Verification
The main flow is run several ways:
- A full correct sequence, which separates a true unlock from partial progress.
- A compare that names the wrong slot, which separates order checking from data checking.
- An unarmed compare that carries the right data, which shows that arming is required.
- A mismatched second byte, which shows that the spent bit is kept.
- Updates that clear no bits and updates that clear three bits, which separate the AND rule from the arming rule.
- Exhausting the counter, which reaches the blocked state.
- A reset after the unlock, which shows that the open state lasts only until reset.

Reads are interleaved throughout, so that hidden and visible reference bytes, and the counter value after each step, are seen at the ports.

// File: rtl/seccode_pkg.sv
package seccode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VERIFY,
        ST_OPEN,
        ST_BLOCKED
    } sc_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_UPD,
        OP_CMP,
        OP_RD
    } sc_op_t;

endpackage

// File: rtl/seccode_store.sv
module seccode_store #(
    parameter int CNT_BITS  = 3,
    parameter int BYTE_W    = 8,
    parameter int REF_BYTES = 3,
    parameter int ADDR_W    = 2,
    parameter logic [CNT_BITS-1:0]         CNT_INIT = '1,
    parameter logic [REF_BYTES*BYTE_W-1:0] REF_INIT = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_we,
    input  logic [CNT_BITS-1:0]         cnt_wdata,
    input  logic                        ref_we,
    input  logic [ADDR_W-1:0]           ref_sel,
    input  logic [BYTE_W-1:0]           ref_wdata,
    output logic [CNT_BITS-1:0]         cnt_q,
    output logic [REF_BYTES*BYTE_W-1:0] ref_flat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_INIT;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end
    end

    // One register per reference slot; slot i+1 maps to byte lane i.
    for (genvar gi = 0; gi < REF_BYTES; gi++) begin : g_ref
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= REF_INIT[gi*BYTE_W +: BYTE_W];
            end else if (ref_we && ref_sel == ADDR_W'(gi + 1)) begin
                byte_q <= ref_wdata;
            end
        end
        assign ref_flat[gi*BYTE_W +: BYTE_W] = byte_q;
    end

endmodule

// File: rtl/seccode_seq.sv
module seccode_seq
    import seccode_pkg::*;
#(
    parameter int CNT_BITS  = 3,
    parameter int BYTE_W    = 8,
    parameter int REF_BYTES = 3,
    parameter int ADDR_W    = 2,
    parameter logic [CNT_BITS-1:0] CNT_INIT = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  sc_op_t                      op,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    input  logic [CNT_BITS-1:0]         cnt_q,
    input  logic [REF_BYTES*BYTE_W-1:0] ref_flat,
    output sc_state_t                   state_q,
    output logic                        unlocked,
    output logic                        cmd_done,
    output logic                        cmd_ok,
    output logic                        cnt_we,
    output logic [CNT_BITS-1:0]         cnt_wdata,
    output logic                        ref_we,
    output logic [ADDR_W-1:0]           ref_sel,
    output logic [BYTE_W-1:0]           ref_wdata
);

    localparam logic [ADDR_W-1:0] LAST_STEP  = ADDR_W'(REF_BYTES - 1);
    localparam sc_state_t         RESET_ST   = (CNT_INIT == '0) ? ST_BLOCKED : ST_IDLE;

    sc_state_t             state_d;
    logic [ADDR_W-1:0]     step_q, step_d;
    logic                  ok_d, done_d;
    logic [CNT_BITS-1:0]   and_cnt, cleared;
    logic [ADDR_W:0]       n_clr;
    logic                  ref_hit, addr_is_ref;
    sc_state_t             fail_st, upd_fail_st;

    // Counter bits this update would clear, and how many of them.
    always_comb begin
        and_cnt = cnt_q & wdata[CNT_BITS-1:0];
        cleared = cnt_q & ~wdata[CNT_BITS-1:0];
        n_clr   = '0;
        for (int i = 0; i < CNT_BITS; i++) begin
            n_clr = n_clr + (ADDR_W+1)'(cleared[i]);
        end
    end

    // Match of the guess against the addressed reference slot.
    always_comb begin
        ref_hit     = 1'b0;
        addr_is_ref = 1'b0;
        for (int i = 0; i < REF_BYTES; i++) begin
            if (addr == ADDR_W'(i + 1)) begin
                addr_is_ref = 1'b1;
                if (ref_flat[i*BYTE_W +: BYTE_W] == wdata) begin
                    ref_hit = 1'b1;
                end
            end
        end
    end

    assign fail_st     = (cnt_q == '0)   ? ST_BLOCKED : ST_IDLE;
    assign upd_fail_st = (and_cnt == '0) ? ST_BLOCKED : ST_IDLE;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_ST;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Next state and store write controls.
    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        ok_d      = 1'b0;
        done_d    = (op == OP_UPD) || (op == OP_CMP);
        cnt_we    = 1'b0;
        cnt_wdata = cnt_q;
        ref_we    = 1'b0;
        ref_sel   = addr;
        ref_wdata = wdata;
        unique case (state_q)
            ST_OPEN: begin
                if (op == OP_UPD) begin
                    ok_d = 1'b1;
                    if (addr == '0) begin
                        cnt_we    = 1'b1;
                        cnt_wdata = wdata[CNT_BITS-1:0];
                    end else if (addr_is_ref) begin
                        ref_we = 1'b1;
                    end
                end else if (op == OP_CMP) begin
                    ok_d = ref_hit;
                end
            end
            ST_BLOCKED: begin
                ok_d = 1'b0;
            end
            ST_IDLE, ST_VERIFY: begin
                if (op == OP_UPD) begin
                    if (addr == '0) begin
                        cnt_we    = 1'b1;
                        cnt_wdata = and_cnt;
                        if (n_clr == (ADDR_W+1)'(1)) begin
                            ok_d    = 1'b1;
                            state_d = ST_VERIFY;
                            step_d  = '0;
                        end else begin
                            state_d = upd_fail_st;
                        end
                    end else begin
                        state_d = fail_st;
                    end
                end else if (op == OP_CMP) begin
                    if (state_q == ST_VERIFY &&
                        addr == ADDR_W'(step_q + ADDR_W'(1)) && ref_hit) begin
                        ok_d = 1'b1;
                        if (step_q == LAST_STEP) begin
                            state_d = ST_OPEN;
                        end else begin
                            step_d = step_q + ADDR_W'(1);
                        end
                    end else begin
                        state_d = fail_st;
                    end
                end
            end
        endcase
    end

    // Registered responses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_done <= 1'b0;
            cmd_ok   <= 1'b0;
            unlocked <= 1'b0;
        end else begin
            cmd_done <= done_d;
            cmd_ok   <= ok_d;
            unlocked <= (state_d == ST_OPEN);
        end
    end

endmodule

// File: rtl/seccode_rdport.sv
module seccode_rdport #(
    parameter int CNT_BITS  = 3,
    parameter int BYTE_W    = 8,
    parameter int REF_BYTES = 3,
    parameter int ADDR_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        unlocked,
    input  logic [CNT_BITS-1:0]         cnt_q,
    input  logic [REF_BYTES*BYTE_W-1:0] ref_flat,
    output logic                        rd_valid,
    output logic [BYTE_W-1:0]           rd_data
);

    logic [BYTE_W-1:0] mux_d;

    always_comb begin
        mux_d = '0;
        if (addr == '0) begin
            mux_d = {{(BYTE_W-CNT_BITS){1'b0}}, cnt_q};
        end else if (unlocked) begin
            for (int i = 0; i < REF_BYTES; i++) begin
                if (addr == ADDR_W'(i + 1)) begin
                    mux_d = ref_flat[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= mux_d;
            end
        end
    end

endmodule

// File: rtl/seccode_unit.sv
module seccode_unit
    import seccode_pkg::*;
#(
    parameter int CNT_BITS  = 3,
    parameter int BYTE_W    = 8,
    parameter int REF_BYTES = 3,
    parameter int ADDR_W    = $clog2(REF_BYTES + 1),
    parameter logic [CNT_BITS-1:0]         CNT_INIT = '1,
    parameter logic [REF_BYTES*BYTE_W-1:0] REF_INIT = 24'h17C35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic              cmp_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              unlocked,
    output logic              cmd_done,
    output logic              cmd_ok,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);

    sc_op_t                      op;
    sc_state_t                   state_q;
    logic [CNT_BITS-1:0]         cnt_q, cnt_wdata;
    logic [REF_BYTES*BYTE_W-1:0] ref_flat;
    logic                        cnt_we, ref_we;
    logic [ADDR_W-1:0]           ref_sel;
    logic [BYTE_W-1:0]           ref_wdata;

    // One command per cycle: update over compare over read.
    always_comb begin
        if (upd_stb)      op = OP_UPD;
        else if (cmp_stb) op = OP_CMP;
        else if (rd_stb)  op = OP_RD;
        else              op = OP_NONE;
    end

    seccode_store #(
        .CNT_BITS(CNT_BITS), .BYTE_W(BYTE_W), .REF_BYTES(REF_BYTES),
        .ADDR_W(ADDR_W), .CNT_INIT(CNT_INIT), .REF_INIT(REF_INIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .ref_we(ref_we), .ref_sel(ref_sel), .ref_wdata(ref_wdata),
        .cnt_q(cnt_q), .ref_flat(ref_flat)
    );

    seccode_seq #(
        .CNT_BITS(CNT_BITS), .BYTE_W(BYTE_W), .REF_BYTES(REF_BYTES),
        .ADDR_W(ADDR_W), .CNT_INIT(CNT_INIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .wdata(wdata),
        .cnt_q(cnt_q), .ref_flat(ref_flat), .state_q(state_q),
        .unlocked(unlocked), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .ref_we(ref_we), .ref_sel(ref_sel), .ref_wdata(ref_wdata)
    );

    seccode_rdport #(
        .CNT_BITS(CNT_BITS), .BYTE_W(BYTE_W), .REF_BYTES(REF_BYTES),
        .ADDR_W(ADDR_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(op == OP_RD), .addr(addr),
        .unlocked(unlocked), .cnt_q(cnt_q), .ref_flat(ref_flat),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: rtl/seccode_checker.sv
module seccode_checker
    import seccode_pkg::*;
#(
    parameter int CNT_BITS  = 3,
    parameter int BYTE_W    = 8,
    parameter int REF_BYTES = 3,
    parameter int ADDR_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                upd_stb,
    input logic                cmp_stb,
    input logic                rd_stb,
    input logic [ADDR_W-1:0]   addr,
    input logic                unlocked,
    input logic                cmd_done,
    input logic                cmd_ok,
    input logic                rd_valid,
    input logic [BYTE_W-1:0]   rd_data,
    input logic [CNT_BITS-1:0] cnt_q,
    input sc_state_t           state_q
);

    logic rd_only;
    assign rd_only = rd_stb && !upd_stb && !cmp_stb;

    p_cnt_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ((cnt_q & ~$past(cnt_q)) == '0));

    p_open_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    p_unlock_after_last_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(cmp_stb) && !$past(upd_stb) &&
                             $past(addr) == ADDR_W'(REF_BYTES)));

    p_hidden_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && !unlocked && addr != '0) |=> (rd_data == '0));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && addr == '0) |=> (rd_data[BYTE_W-1:CNT_BITS] == '0));

    p_blocked_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED) |=> (!cmd_ok && !unlocked));

    p_done_follows_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb || cmp_stb) |=> cmd_done);

    p_done_only_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_stb || cmp_stb) |=> !cmd_done);

    p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only |=> rd_valid);

endmodule

bind seccode_unit seccode_checker #(
    .CNT_BITS(CNT_BITS), .BYTE_W(BYTE_W), .REF_BYTES(REF_BYTES), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .cmp_stb(cmp_stb),
    .rd_stb(rd_stb), .addr(addr), .unlocked(unlocked), .cmd_done(cmd_done),
    .cmd_ok(cmd_ok), .rd_valid(rd_valid), .rd_data(rd_data),
    .cnt_q(cnt_q), .state_q(state_q)
);

// File: tb/seccode_unit_bench.sv
module seccode_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0, cmp_stb = 1'b0, rd_stb = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       unlocked, cmd_done, cmd_ok, rd_valid;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    seccode_unit u_seccode_unit (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .cmp_stb(cmp_stb),
        .rd_stb(rd_stb), .addr(addr), .wdata(wdata), .unlocked(unlocked),
        .cmd_done(cmd_done), .cmd_ok(cmd_ok), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    // Vector: op[21:20] (1 upd, 2 cmp, 3 rd), addr[19:18], data[17:10],
    //         exp_ok[9], exp_unlocked[8], exp_rd[7:0]
    localparam int NV = 23;
    localparam logic [21:0] VEC [NV] = '{
        {2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 8'h07},
        {2'd3, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00},
        {2'd2, 2'd1, 8'h5A, 1'b0, 1'b0, 8'h00},
        {2'd1, 2'd1, 8'hFF, 1'b0, 1'b0, 8'h00},
        {2'd1, 2'd0, 8'hFE, 1'b1, 1'b0, 8'h00},
        {2'd2, 2'd2, 8'hC3, 1'b0, 1'b0, 8'h00},
        {2'd2, 2'd1, 8'h5A, 1'b0, 1'b0, 8'h00},
        {2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 8'h06},
        {2'd1, 2'd0, 8'hFC, 1'b1, 1'b0, 8'h00},
        {2'd2, 2'd1, 8'h5A, 1'b1, 1'b0, 8'h00},
        {2'd2, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00},
        {2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 8'h04},
        {2'd1, 2'd0, 8'hFF, 1'b0, 1'b0, 8'h00},
        {2'd1, 2'd0, 8'hFB, 1'b1, 1'b0, 8'h00},
        {2'd2, 2'd1, 8'h5A, 1'b1, 1'b0, 8'h00},
        {2'd2, 2'd2, 8'hC3, 1'b1, 1'b0, 8'h00},
        {2'd2, 2'd3, 8'h17, 1'b1, 1'b1, 8'h00},
        {2'd3, 2'd1, 8'h00, 1'b0, 1'b1, 8'h5A},
        {2'd1, 2'd0, 8'hFF, 1'b1, 1'b1, 8'h00},
        {2'd3, 2'd0, 8'h00, 1'b0, 1'b1, 8'h07},
        {2'd1, 2'd2, 8'h99, 1'b1, 1'b1, 8'h00},
        {2'd3, 2'd2, 8'h00, 1'b0, 1'b1, 8'h99},
        {2'd3, 2'd3, 8'h00, 1'b0, 1'b1, 8'h17}
    };
    localparam string TAG [NV] = '{
        "R2", "R9", "R6", "R4", "R5", "R6", "R6", "R3",
        "R5", "R5", "R7", "R7", "R12", "R5", "R5", "R5",
        "R5", "R10", "R10", "R10", "R10", "R10", "R4"
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        upd_stb = (op == 2'd1);
        cmp_stb = (op == 2'd2);
        rd_stb  = (op == 2'd3);
        addr    = a;
        wdata   = d;
        @(negedge clk);
        upd_stb = 1'b0;
        cmp_stb = 1'b0;
        rd_stb  = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 unlocked", {7'd0, unlocked}, 8'h00);
        chk("R1 done", {6'd0, cmd_done, cmd_ok}, 8'h00);
        chk("R1 rd", {rd_valid, 7'd0} | rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VEC[i];
            run_op(v[21:20], v[19:18], v[17:10]);
            chk(TAG[i], {7'd0, unlocked}, {7'd0, v[8]});
            if (v[21:20] == 2'd3) begin
                chk(TAG[i], {7'd0, rd_valid}, 8'h01);
                chk(TAG[i], rd_data, v[7:0]);
            end else begin
                chk(TAG[i], {7'd0, cmd_done}, 8'h01);
                chk(TAG[i], {7'd0, cmd_ok}, {7'd0, v[9]});
            end
        end

        // R11: done is a single-cycle pulse
        run_op(2'd1, 2'd1, 8'h44);
        chk("R11 done high", {7'd0, cmd_done}, 8'h01);
        @(negedge clk);
        chk("R11 done low", {7'd0, cmd_done}, 8'h00);
        chk("R11 rd_valid low", {7'd0, rd_valid}, 8'h00);

        // R11 priority: update wins over read
        @(negedge clk);
        upd_stb = 1'b1; rd_stb = 1'b1; addr = 2'd3; wdata = 8'h21;
        @(negedge clk);
        upd_stb = 1'b0; rd_stb = 1'b0;
        chk("R11 prio done", {6'd0, cmd_done, rd_valid}, 8'h02);
        run_op(2'd3, 2'd3, 8'h00);
        chk("R11 prio data", rd_data, 8'h21);

        // R10: reset ends the open state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 relock", {7'd0, unlocked}, 8'h00);
        run_op(2'd3, 2'd0, 8'h00);
        chk("R1 counter init", rd_data, 8'h07);
        run_op(2'd3, 2'd1, 8'h00);
        chk("R9 hidden after reset", rd_data, 8'h00);

        // R12: clearing three bits at once does not arm
        run_op(2'd1, 2'd0, 8'hF8);
        chk("R12 multi clear", {7'd0, cmd_ok}, 8'h00);
        run_op(2'd3, 2'd0, 8'h00);
        chk("R3 counter zero", rd_data, 8'h00);
        // R8: exhausted counter refuses everything
        run_op(2'd2, 2'd1, 8'h5A);
        chk("R8 cmp refused", {6'd0, cmd_ok, unlocked}, 8'h00);
        run_op(2'd1, 2'd0, 8'hFF);
        chk("R8 upd refused", {6'd0, cmd_ok, unlocked}, 8'h00);
        run_op(2'd1, 2'd2, 8'h00);
        chk("R8 ref upd refused", {6'd0, cmd_ok, unlocked}, 8'h00);
        run_op(2'd3, 2'd0, 8'h00);
        chk("R8 counter stays", rd_data, 8'h00);

        finish_run();
    end

endmodule